// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block reads one conversion result from an external serial analog-to-digital converter over a three-wire link: a serial clock, a converter enable line and a serial data input. Every register runs on the single master clock. The serial clock is not a derived clock net. A counter produces one-cycle enable pulses, and these pulses toggle a registered serial clock output and mark the edges where data is launched and sampled.

A one-cycle start request in the idle state raises the converter enable and the busy flag. The block lets the converter settle for a fixed number of serial clock periods. It then shifts in the whole result word in one continuous run of serial clock periods, with no gap between bits. The finished word appears on a parallel output together with a one-cycle valid strobe. In the same cycle the enable line drops and the block returns to idle. The serial data input passes through a two-flop synchronizer before it is sampled.

Top module: `adc_capture`

## Requirements
- R1: The serial clock period is DIV_RATIO master clock cycles (default 32), with the clock high for DIV_RATIO/2 cycles and low for DIV_RATIO/2 cycles. The serial clock changes only after an internal rise or fall enable pulse.
- R2: A start request in idle raises busy_o and cnv_en_o one master cycle later. The serial clock is low at that point and stays low for the first half period.
- R3: After the enable rises, the block lets WAIT_CYC full serial clock periods (default 5) pass before any data is sampled. The bit sampled on the (WAIT_CYC+1)-th falling edge is the word's MSB.
- R4: A conversion produces exactly WAIT_CYC+WORD_W rising edges of the serial clock (default 21), all at the uniform period of R1, with no pause between data bits.
- R5: The converter launches each data bit after a rising edge of the serial clock, and the block samples it at the following falling edge. Bits arrive MSB first, so bit WORD_W-1 comes first and bit 0 comes last.
- R6: valid_o is high for exactly one master cycle: the cycle in which busy_o and cnv_en_o fall. In that cycle dout_o holds the captured word. dout_o does not change in any other cycle.
- R7: busy_o stays high from the cycle after an accepted start until the enable is released. A start request while busy_o is high is ignored: the conversion keeps its edge count and produces one valid strobe with the correct word.
- R8: While rst_ni is low, and right after it is released, cnv_en_o, busy_o, valid_o and sclk_o are 0 and dout_o is all zeros. The serial clock is low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle conversion request |
| sdi_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| cnv_en_o | output | 1 | Converter enable, active high |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| dout_o | output | WORD_W | Last captured result word |

## Verification
If the wait or bit counter is wrong, the block gives the wrong number of serial clock rising edges, or the data word comes out shifted by whole bit positions. Either error is visible when the enable falls, about 21 serial periods after the start. A fault in the divider phase changes the length of the high or low serial clock segment, and this shows within the first serial period. If the state machine leaves its idle state on a start while busy, the edge count and the valid strobe are disturbed, and this shows at the end of the conversion in which the extra start arrived.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } cap_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_RATIO = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || cnt_q == FALL_AT) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_o = run_i && (cnt_q == RISE_AT);
  assign fall_o = run_i && (cnt_q == FALL_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      sclk_q <= 1'b0;
    end else if (rise_o) begin
      sclk_q <= 1'b1;
    end else if (fall_o) begin
      sclk_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/adc_din_sync.sv
module adc_din_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] next_o
);
  logic [WORD_W-1:0] sr_q;

  // word including the bit being sampled this cycle
  assign next_o = {sr_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (clr_i) begin
      sr_q <= '0;
    end else if (shift_i) begin
      sr_q <= next_o;
    end
  end

  assign word_o = sr_q;
endmodule

// File: rtl/adc_capture.sv
module adc_capture
  import adc_cap_pkg::*;
#(
  parameter int DIV_RATIO   = 32,
  parameter int WAIT_CYC    = 5,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              cnv_en_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] dout_o
);
  localparam int CNT_MAX = max_int(WAIT_CYC, WORD_W);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(WORD_W - 1);

  cap_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;
  logic [WORD_W-1:0] dout_q;
  logic              run;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              sdi_s;
  logic              accept;
  logic              do_shift;
  logic [WORD_W-1:0] sr_word;
  logic [WORD_W-1:0] sr_next;

  assign run      = (state_q != ST_IDLE);
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign do_shift = (state_q == ST_SHIFT) && sclk_fall;

  adc_sclk_gen #(.DIV_RATIO(DIV_RATIO)) i_sclk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sclk_o (sclk_o),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  adc_din_sync #(.STAGES(SYNC_STAGES)) i_din_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sdi_i),
    .q_o    (sdi_s)
  );

  adc_shift_in #(.WORD_W(WORD_W)) i_shift_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .shift_i (do_shift),
    .bit_i   (sdi_s),
    .word_o  (sr_word),
    .next_o  (sr_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= (WAIT_CYC > 0) ? ST_WAIT : ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_WAIT: begin
          if (sclk_fall) begin
            if (cnt_q == WAIT_LAST) begin
              state_q <= ST_SHIFT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (sclk_fall) begin
            if (cnt_q == BIT_LAST) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
              dout_q  <= sr_next;
              valid_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = run;
  assign cnv_en_o = run;
  assign valid_o  = valid_q;
  assign dout_o   = dout_q;

  logic unused_sr;
  assign unused_sr = ^sr_word;
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              sclk_o,
  input logic              busy_o,
  input logic              valid_o,
  input logic [WORD_W-1:0] dout_o,
  input logic              sclk_rise_i,
  input logic              sclk_fall_i
);
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_rise_i && sclk_fall_i)); // R1
  AST_RISE_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_i |-> !sclk_o); // R1
  AST_SCLK_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> $past(sclk_rise_i || sclk_fall_i || busy_o)); // R1
  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !sclk_o)); // R2
  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_VALID_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o); // R6
  AST_VALID_ONLY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $fell(busy_o)); // R6
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(dout_o)); // R6
  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o); // R8
endmodule

bind adc_capture adc_capture_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .sclk_o      (sclk_o),
  .busy_o      (busy_o),
  .valid_o     (valid_o),
  .dout_o      (dout_o),
  .sclk_rise_i (sclk_rise),
  .sclk_fall_i (sclk_fall)
);

// File: tb/test_adc_capture.sv
module test_adc_capture;
  localparam int DIV  = 32;
  localparam int WAIT = 5;
  localparam int W    = 16;
  localparam int HALF = DIV / 2;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         sdi_i = 1'b0;
  logic         sclk_o, cnv_en_o, busy_o, valid_o;
  logic [W-1:0] dout_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5ns clk = ~clk;

  adc_capture #(.DIV_RATIO(DIV), .WAIT_CYC(WAIT), .WORD_W(W), .SYNC_STAGES(2)) i_adc_capture (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .sdi_i (sdi_i),
    .sclk_o (sclk_o), .cnv_en_o (cnv_en_o), .busy_o (busy_o),
    .valid_o (valid_o), .dout_o (dout_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(cnv_en_o == 1'b0, req, "cnv_en idle", cnv_en_o, 0);
    chk(busy_o == 1'b0, req, "busy idle", busy_o, 0);
    chk(sclk_o == 1'b0, req, "sclk idle", sclk_o, 0);
    chk(valid_o == 1'b0, req, "valid idle", valid_o, 0);
  endtask

  // converter model: drives bit after each rising edge beyond the wait periods
  task automatic convert(input logic [W-1:0] w, input bit poke);
    int rises = 0;
    int seg = 0;
    int cyc = 0;
    int bad_seg = 0;
    bit early_valid = 1'b0;
    bit poked = 1'b0;
    logic prev;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    // R2: enable and busy one cycle after the request, sclk low
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    chk(cnv_en_o == 1'b1, "R2", "cnv_en after start", cnv_en_o, 1);
    chk(sclk_o == 1'b0, "R2", "sclk low after start", sclk_o, 0);
    prev = sclk_o;
    while (busy_o && cyc < 5000) begin
      if (start_i) start_i = 1'b0;
      if (sclk_o != prev) begin
        if (seg != HALF) bad_seg++;
        seg = 0;
        if (sclk_o) begin
          rises++;
          if (rises > WAIT && rises <= WAIT + W) sdi_i = w[W - (rises - WAIT)];
          else sdi_i = 1'b0;
        end
      end
      seg++;
      prev = sclk_o;
      if (valid_o) early_valid = 1'b1;
      if (poke && !poked && rises == 8) begin
        start_i = 1'b1;
        poked = 1'b1;
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (prev == 1'b1 && seg != HALF) bad_seg++;
    chk(bad_seg == 0, "R1", "uneven sclk segments", bad_seg, 0);
    chk(rises == WAIT + W, poke ? "R7" : "R4", "sclk rising edges", rises, WAIT + W);
    chk(!early_valid, "R6", "valid while busy", early_valid, 0);
    chk(valid_o == 1'b1, "R6", "valid at enable drop", valid_o, 1);
    chk(dout_o == w, poke ? "R7" : "R5", "captured word", dout_o, w);
    chk(cnv_en_o == 1'b0, "R7", "cnv_en released", cnv_en_o, 0);
    @(negedge clk);
    chk(valid_o == 1'b0, "R6", "valid one cycle", valid_o, 1'b0);
    chk(dout_o == w, "R6", "dout held", dout_o, w);
    chk(busy_o == 1'b0, "R7", "no restart after ignored start", busy_o, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #3_000_000ns;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(negedge clk);
    check_idle("R8");
    chk(dout_o == '0, "R8", "dout in reset", dout_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R8");
    chk(dout_o == '0, "R8", "dout after reset", dout_o, 0);

    // R5 R3: corner words make wait-count or bit-order slips visible
    convert(16'h0000, 1'b0);
    convert(16'hFFFF, 1'b0);
    convert(16'h8000, 1'b0);
    convert(16'h0001, 1'b0);
    convert(16'hAAAA, 1'b0);
    convert(16'h5555, 1'b0);
    for (int i = 0; i < W; i++) convert(16'(1) << i, 1'b0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 6; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      convert(lfsr, 1'b0);
    end

    // R7: start while busy ignored
    convert(16'h1234, 1'b1);
    convert(16'hC3A5, 1'b1);

    // R8: reset in mid conversion returns to idle
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (100) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check_idle("R8");
    chk(dout_o == '0, "R8", "dout cleared by reset", dout_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R8");
    convert(16'h7E81, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule